// File: doc/BRIEF.md
# Product-Term Logic Block with Fast Bypass Paths

This block is one logic cell of a sum-of-products programmable fabric. It takes a 24-bit routing bus and builds a set of product terms from it in a single AND plane. Each term is the AND of any chosen mix of true and complemented bus bits. The data terms are split into two halves, and each half feeds four outputs through its own OR/XOR stage. For every output, a static setting chooses one of three paths:
- a wide sum over a programmable subset of the twenty terms of its half, XORed with a dedicated term;
- a fast OR of the output's own four terms;
- one term XORed with the dedicated term.

Each output is then either passed straight through or captured in a flip-flop. Three further product terms are set aside for control. The first can act as the flip-flop clock, in place of one of three global clocks. The second can clear the flip-flops. The third is brought out as an output-enable toward the pad logic. All eight outputs return to the routing fabric whether they are registered or not.

The whole configuration is fixed at elaboration through parameters: the AND plane masks, the per-output OR masks, the path codes, the register enables, the clock choice and the term-reset enable.

Top module: `pterm_logic_block`

## Requirements
- R1: A product term is true when every selected true literal sees a 1 and every selected complemented literal sees a 0. A term with no literals is constantly 1. A term that selects both polarities of one bus bit is constantly 0.
- R2: Path code 2'b00 (code of output j at bits [2j+1:2j] of the path setting) gives the OR of the half's twenty data terms, gated by the output's 20-bit OR mask, XORed with the output's dedicated term in slot 4.
- R3: Path code 2'b01 gives the OR of the output's own slots 0 to 3. The OR mask and slot 4 have no effect on it.
- R4: Path codes 2'b10 and 2'b11 give slot 0 XOR slot 4.
- R5: An output whose register-enable bit is 0 follows the bus in the same cycle. An output whose bit is 1 shows the path value captured at the last rising edge of the register clock.
- R6: While rstN is low, every registered output reads 0 at once. Unregistered outputs keep following the bus.
- R7: A clock select of 0, 1 or 2 clocks the registers from that global clock. A select of 3 clocks them from the rising edge of control term 40. With select 3 the global clocks have no effect.
- R8: With term reset enabled, control term 41 clears every register while it is true. The registers stay clear until the next register-clock edge after it falls.
- R9: outEn equals control term 42.
- R10: Data term numbering: output j = 4h+k (half h, slot group k) owns terms 20h+5k+t for t = 0..4. OR-mask bit i of output j (bit 20j+i) refers to term 20h+i. Masks for term p sit at bits [24p+23:24p].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| gclk | input | 3 | Global clocks selectable as the register clock |
| rstN | input | 1 | Active-low asynchronous clear of all registers |
| busIn | input | 24 | Routing bus inputs to the AND plane |
| dataOut | output | 8 | Block outputs, also fed back to routing |
| outEn | output | 1 | Output-enable term toward the pad logic |

## Verification
The bench aims at the literal corners of the AND plane. An always-true empty term combined with a contradictory slot-4 term must give a constant 1 on one output; a plane that defaulted empty terms to 0, or ignored complemented literals, would flip that output. It also checks that the fast path ignores the OR mask and the XOR slot; a design that shared the wide sum there would disagree with the model on random bus values. On the term-clocked instance it holds data steady across global clock edges and raises the clock term only after the data settles, so a design wired to the wrong clock would capture early or late. It also asserts the clear term across a clock-term edge; a clear treated as synchronous, or ignored, would let data through.

// File: rtl/plb_pkg.sv
`timescale 1ns/1ps
package plb_pkg;
  // Strobes the control side hands to the datapath registers.
  typedef struct packed {
    logic regClk;
    logic regClear;
  } plb_ctrl_t;

  localparam logic [1:0] PATH_SUM  = 2'b00;
  localparam logic [1:0] PATH_FAST = 2'b01;
endpackage

// File: rtl/plb_and_array.sv
`timescale 1ns/1ps
module plb_and_array #(
  parameter int NUM_IN = 24,
  parameter int NUM_PT = 43,
  parameter logic [NUM_PT*NUM_IN-1:0] TRUE_MASK = '0,
  parameter logic [NUM_PT*NUM_IN-1:0] COMP_MASK = '0
) (
  input  logic [NUM_IN-1:0] busIn,
  output logic [NUM_PT-1:0] ptVec
);
  // One AND gate per term; an unselected literal contributes a 1.
  for (genvar p = 0; p < NUM_PT; p++) begin : g_term
    localparam logic [NUM_IN-1:0] TM = TRUE_MASK[p*NUM_IN +: NUM_IN];
    localparam logic [NUM_IN-1:0] CM = COMP_MASK[p*NUM_IN +: NUM_IN];
    assign ptVec[p] = &((busIn | ~TM) & (~busIn | ~CM));
  end
endmodule

// File: rtl/plb_ctrl.sv
`timescale 1ns/1ps
module plb_ctrl #(
  parameter int NUM_GCLK  = 3,
  parameter int CLK_SEL   = 0,
  parameter bit PT_RST_EN = 1'b0
) (
  input  logic [NUM_GCLK-1:0] gclk,
  input  logic                rstN,
  input  logic                ptClkTerm,
  input  logic                ptRstTerm,
  input  logic                ptOeTerm,
  output plb_pkg::plb_ctrl_t  ctl,
  output logic                outEn
);
  // Select index NUM_GCLK picks the product-term clock.
  localparam logic [NUM_GCLK:0] CLK_PICK = {{NUM_GCLK{1'b0}}, 1'b1} << CLK_SEL;

  logic [NUM_GCLK:0] clkChoices;
  assign clkChoices   = {ptClkTerm, gclk};
  assign ctl.regClk   = |(clkChoices & CLK_PICK);
  assign ctl.regClear = ~rstN | (PT_RST_EN & ptRstTerm);
  assign outEn        = ptOeTerm;
endmodule

// File: rtl/plb_datapath.sv
`timescale 1ns/1ps
module plb_datapath #(
  parameter int NUM_OUT       = 8,
  parameter int NUM_HALF      = 2,
  parameter int TERMS_PER_OUT = 5,
  parameter logic [NUM_OUT*(NUM_OUT/NUM_HALF)*TERMS_PER_OUT-1:0] OR_MASK = '0,
  parameter logic [2*NUM_OUT-1:0] PATH_SEL = '0,
  parameter logic [NUM_OUT-1:0]   REG_EN   = '0
) (
  input  logic [NUM_OUT*TERMS_PER_OUT-1:0] dataPt,
  input  plb_pkg::plb_ctrl_t               ctl,
  output logic [NUM_OUT-1:0]               combVec,
  output logic [NUM_OUT-1:0]               dataOut
);
  localparam int OUT_PER_HALF   = NUM_OUT / NUM_HALF;
  localparam int TERMS_PER_HALF = OUT_PER_HALF * TERMS_PER_OUT;
  localparam int FAST_TERMS     = TERMS_PER_OUT - 1;
  localparam int XOR_SLOT       = TERMS_PER_OUT - 1;

  logic regClk, regClear;
  assign regClk   = ctl.regClk;
  assign regClear = ctl.regClear;

  for (genvar j = 0; j < NUM_OUT; j++) begin : g_out
    localparam int HALF_BASE = (j / OUT_PER_HALF) * TERMS_PER_HALF;
    localparam int OWN_BASE  = HALF_BASE + (j % OUT_PER_HALF) * TERMS_PER_OUT;
    localparam logic [1:0] CODE = PATH_SEL[2*j +: 2];

    logic [TERMS_PER_HALF-1:0] halfTerms;
    logic xorTerm, sumPath, fastPath, onePath, pathOut;

    assign halfTerms = dataPt[HALF_BASE +: TERMS_PER_HALF]
                     & OR_MASK[j*TERMS_PER_HALF +: TERMS_PER_HALF];
    assign xorTerm   = dataPt[OWN_BASE + XOR_SLOT];
    assign sumPath   = (|halfTerms) ^ xorTerm;
    assign fastPath  = |dataPt[OWN_BASE +: FAST_TERMS];
    assign onePath   = dataPt[OWN_BASE] ^ xorTerm;

    always_comb begin
      case (CODE)
        plb_pkg::PATH_SUM:  pathOut = sumPath;
        plb_pkg::PATH_FAST: pathOut = fastPath;
        default:            pathOut = onePath;
      endcase
    end
    assign combVec[j] = pathOut;

    if (REG_EN[j]) begin : g_reg
      logic q;
      always_ff @(posedge regClk or posedge regClear) begin
        if (regClear) q <= 1'b0;
        else          q <= pathOut;
      end
      assign dataOut[j] = q;
    end else begin : g_comb
      assign dataOut[j] = pathOut;
    end
  end
endmodule

// File: rtl/pterm_logic_block.sv
`timescale 1ns/1ps
module pterm_logic_block #(
  parameter int NUM_IN        = 24,
  parameter int NUM_OUT       = 8,
  parameter int NUM_HALF      = 2,
  parameter int TERMS_PER_OUT = 5,
  parameter int NUM_GCLK      = 3,
  parameter logic [(NUM_OUT*TERMS_PER_OUT+3)*NUM_IN-1:0] TRUE_MASK = '0,
  parameter logic [(NUM_OUT*TERMS_PER_OUT+3)*NUM_IN-1:0] COMP_MASK = '0,
  parameter logic [NUM_OUT*(NUM_OUT/NUM_HALF)*TERMS_PER_OUT-1:0] OR_MASK = '0,
  parameter logic [2*NUM_OUT-1:0] PATH_SEL  = '0,
  parameter logic [NUM_OUT-1:0]   REG_EN    = '0,
  parameter int                   CLK_SEL   = 0,
  parameter bit                   PT_RST_EN = 1'b0
) (
  input  logic [NUM_GCLK-1:0] gclk,
  input  logic                rstN,
  input  logic [NUM_IN-1:0]   busIn,
  output logic [NUM_OUT-1:0]  dataOut,
  output logic                outEn
);
  localparam int NUM_DATA_PT = NUM_OUT * TERMS_PER_OUT;
  localparam int NUM_PT      = NUM_DATA_PT + 3;
  localparam int CLK_TERM    = NUM_DATA_PT;
  localparam int RST_TERM    = NUM_DATA_PT + 1;
  localparam int OE_TERM     = NUM_DATA_PT + 2;

  logic [NUM_PT-1:0]  ptVec;
  logic [NUM_OUT-1:0] combVec;
  plb_pkg::plb_ctrl_t ctl;

  plb_and_array #(
    .NUM_IN(NUM_IN), .NUM_PT(NUM_PT),
    .TRUE_MASK(TRUE_MASK), .COMP_MASK(COMP_MASK)
  ) u_plane (
    .busIn(busIn), .ptVec(ptVec)
  );

  plb_ctrl #(
    .NUM_GCLK(NUM_GCLK), .CLK_SEL(CLK_SEL), .PT_RST_EN(PT_RST_EN)
  ) u_ctrl (
    .gclk(gclk), .rstN(rstN),
    .ptClkTerm(ptVec[CLK_TERM]), .ptRstTerm(ptVec[RST_TERM]),
    .ptOeTerm(ptVec[OE_TERM]),
    .ctl(ctl), .outEn(outEn)
  );

  plb_datapath #(
    .NUM_OUT(NUM_OUT), .NUM_HALF(NUM_HALF), .TERMS_PER_OUT(TERMS_PER_OUT),
    .OR_MASK(OR_MASK), .PATH_SEL(PATH_SEL), .REG_EN(REG_EN)
  ) u_dp (
    .dataPt(ptVec[NUM_DATA_PT-1:0]), .ctl(ctl),
    .combVec(combVec), .dataOut(dataOut)
  );
endmodule

// File: rtl/plb_checker.sv
`timescale 1ns/1ps
module plb_checker #(
  parameter int NUM_IN  = 24,
  parameter int NUM_OUT = 8,
  parameter logic [NUM_OUT-1:0] REG_EN = '0,
  parameter int CLK_SEL   = 0,
  parameter bit PT_RST_EN = 1'b0
) (
  input logic               sampleClk,
  input logic               rstN,
  input logic [NUM_IN-1:0]  busIn,
  input logic [NUM_OUT-1:0] dataOut,
  input logic [NUM_OUT-1:0] combVec,
  input logic               clearStrobe
);
  localparam logic [NUM_OUT-1:0] REG_MASK  = REG_EN;
  localparam logic [NUM_OUT-1:0] COMB_MASK = ~REG_EN;

  // R6: registered outputs read zero whenever reset is held
  a_r6_async_clear: assert property (@(negedge sampleClk)
    !rstN |-> ((dataOut & REG_MASK) == '0));

  // R8: a live clear strobe keeps every register at zero
  a_r8_term_clear: assert property (@(negedge sampleClk) disable iff (!rstN)
    clearStrobe |-> ((dataOut & REG_MASK) == '0));

  // R5: unregistered outputs move only when the bus moves
  a_r5_comb_follows: assert property (@(posedge sampleClk) disable iff (!rstN)
    $stable(busIn) |-> $stable(dataOut & COMB_MASK));

  // R5, R7: with global clock 0 selected, registers show the path value of the prior edge
  if (CLK_SEL == 0 && !PT_RST_EN) begin : g_capture
    a_r5_reg_capture: assert property (@(posedge sampleClk) disable iff (!rstN)
      $past(rstN) |-> ((dataOut & REG_MASK) == ($past(combVec) & REG_MASK)));
  end
endmodule

bind pterm_logic_block plb_checker #(
  .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .REG_EN(REG_EN),
  .CLK_SEL(CLK_SEL), .PT_RST_EN(PT_RST_EN)
) u_chk (
  .sampleClk(gclk[0]), .rstN(rstN), .busIn(busIn), .dataOut(dataOut),
  .combVec(combVec), .clearStrobe(ctl.regClear)
);

// File: tb/sim_pterm_logic_block.sv
`timescale 1ns/1ps
module sim_pterm_logic_block;
  localparam int NIN = 24;
  localparam int NOUT = 8;
  localparam int NPT = 43;
  localparam int MW = NPT*NIN;

  // ---- configuration of u0 (global clock 0, mixed paths) ----
  function automatic logic [MW-1:0] u0True();
    logic [MW-1:0] m = '0;
    for (int p = 0; p < NPT; p++) begin
      if (p == 42) m[p*NIN+20] = 1'b1;
      else if (p == 14) m[p*NIN+3] = 1'b1;
      else if (p != 10) begin
        m[p*NIN + (p*7+3)%NIN] = 1'b1;
        m[p*NIN + (p*5+1)%NIN] = 1'b1;
      end
    end
    return m;
  endfunction

  function automatic logic [MW-1:0] u0Comp();
    logic [MW-1:0] m = '0;
    for (int p = 0; p < NPT; p++) begin
      int c;
      c = (p*11+5)%NIN;
      if (p == 14) m[p*NIN+3] = 1'b1;
      else if (p != 10 && p != 42 && c != (p*7+3)%NIN && c != (p*5+1)%NIN)
        m[p*NIN+c] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [NOUT*20-1:0] u0Or();
    logic [NOUT*20-1:0] m = '0;
    for (int j = 0; j < NOUT; j++)
      for (int i = 0; i < 20; i++)
        m[j*20+i] = ((j*7 + i*3) % 5) < 2;
    return m;
  endfunction

  localparam logic [MW-1:0] T0 = u0True();
  localparam logic [MW-1:0] C0 = u0Comp();
  localparam logic [NOUT*20-1:0] O0 = u0Or();
  localparam logic [15:0] P0 = 16'b11_10_01_00_11_10_01_00;
  localparam logic [7:0]  E0 = 8'hF0;

  // ---- configuration of u1 (term clock, term reset, fast paths) ----
  function automatic logic [MW-1:0] u1True();
    logic [MW-1:0] m = '0;
    for (int p = 0; p < 40; p++)
      if (p % 5 == 0) m[p*NIN + 8 + p/5] = 1'b1;
      else m[p*NIN] = 1'b1;
    m[40*NIN]      = 1'b1;
    m[41*NIN + 23] = 1'b1;
    return m;
  endfunction

  function automatic logic [MW-1:0] u1Comp();
    logic [MW-1:0] m = '0;
    for (int p = 0; p < 40; p++)
      if (p % 5 != 0) m[p*NIN] = 1'b1;
    m[42*NIN + 5] = 1'b1;
    return m;
  endfunction

  localparam logic [MW-1:0] T1 = u1True();
  localparam logic [MW-1:0] C1 = u1Comp();

  logic clk = 1'b0;
  logic rstN;
  logic [NIN-1:0] bus0, bus1;
  logic [NOUT-1:0] out0, out1;
  logic oe0, oe1;
  logic [NOUT-1:0] expReg;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pterm_logic_block #(
    .TRUE_MASK(T0), .COMP_MASK(C0), .OR_MASK(O0),
    .PATH_SEL(P0), .REG_EN(E0), .CLK_SEL(0), .PT_RST_EN(1'b0)
  ) u0 (
    .gclk({1'b0, 1'b0, clk}), .rstN(rstN), .busIn(bus0),
    .dataOut(out0), .outEn(oe0)
  );

  pterm_logic_block #(
    .TRUE_MASK(T1), .COMP_MASK(C1), .OR_MASK('0),
    .PATH_SEL(16'h5555), .REG_EN(8'hFF), .CLK_SEL(3), .PT_RST_EN(1'b1)
  ) u1 (
    .gclk({clk, clk, clk}), .rstN(rstN), .busIn(bus1),
    .dataOut(out1), .outEn(oe1)
  );

  // ---- behavioural reference ----
  function automatic bit termOf(input logic [MW-1:0] tm, input logic [MW-1:0] cm,
                                input int p, input logic [NIN-1:0] b);
    for (int i = 0; i < NIN; i++) begin
      if (tm[p*NIN+i] && !b[i]) return 1'b0;
      if (cm[p*NIN+i] && b[i]) return 1'b0;
    end
    return 1'b1;
  endfunction

  function automatic bit u0Path(input int j, input logic [NIN-1:0] b);
    int h, base;
    bit s;
    h = j / 4;
    base = h*20 + (j%4)*5;
    case (P0[2*j +: 2])
      2'b00: begin
        s = 1'b0;
        for (int i = 0; i < 20; i++)
          if (O0[j*20+i] && termOf(T0, C0, h*20+i, b)) s = 1'b1;
        return s ^ termOf(T0, C0, base+4, b);
      end
      2'b01: begin
        s = 1'b0;
        for (int t = 0; t < 4; t++) if (termOf(T0, C0, base+t, b)) s = 1'b1;
        return s;
      end
      default: return termOf(T0, C0, base, b) ^ termOf(T0, C0, base+4, b);
    endcase
  endfunction

  function automatic string tagOf(input int j);
    string t;
    case (j % 4)
      0: t = "R2 R10";
      1: t = "R3 R10";
      2: t = "R1 R4 R10";
      default: t = "R4 R10";
    endcase
    if (E0[j]) t = {t, " R5"};
    if (!rstN) t = {t, " R6"};
    return t;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compareU0();
    for (int j = 0; j < NOUT; j++) begin
      bit e;
      e = E0[j] ? expReg[j] : u0Path(j, bus0);
      chk(tagOf(j), {31'd0, out0[j]}, {31'd0, e});
    end
    chk("R9 u0 outEn", {31'd0, oe0}, {31'd0, bus0[20]});
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    done = 1'b1;
    $finish;
  endtask

  initial begin
    #(200000*4);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      finishRun();
    end
  end

  initial begin
    rstN = 1'b0;
    bus0 = '0;
    bus1 = '0;
    expReg = '0;
    repeat (3) @(posedge clk);
    #1;
    compareU0();
    chk("R6 u1 cleared", {24'd0, out1}, 32'd0);
    bus0 = 24'hFFFFFF;
    #1;
    compareU0();
    @(posedge clk);
    #1;
    compareU0();
    bus0 = 24'h000000;
    #1 rstN = 1'b1;

    for (int c = 0; c < 400; c++) begin
      @(posedge clk);
      if (rstN) for (int j = 0; j < NOUT; j++) expReg[j] = u0Path(j, bus0);
      else expReg = '0;
      #1;
      compareU0();
      #1;
      case (c)
        0: bus0 = 24'hFFFFFF;
        1: bus0 = 24'h555555;
        2: bus0 = 24'hAAAAAA;
        default: bus0 = 24'($urandom());
      endcase
      if (c == 200) #1 rstN = 1'b0;
      if (c == 201) #1 rstN = 1'b1;
    end
    @(negedge clk);
    chk("R1 empty XOR contradictory term", {31'd0, out0[2]}, 32'd1);

    // ---- u1: product-term clock, clear and enable ----
    bus1 = 24'h00A500;
    repeat (3) @(posedge clk);
    #1;
    chk("R7 no capture without term clock edge", {24'd0, out1}, 32'h00);
    bus1[0] = 1'b1;
    #1;
    chk("R7 capture on term clock rise", {24'd0, out1}, 32'hA5);
    bus1[15:8] = 8'h3C;
    repeat (3) @(posedge clk);
    #1;
    chk("R7 global clocks ignored", {24'd0, out1}, 32'hA5);
    bus1[0] = 1'b0;
    #1;
    chk("R7 falling term edge holds", {24'd0, out1}, 32'hA5);
    bus1[0] = 1'b1;
    #1;
    chk("R7 second capture", {24'd0, out1}, 32'h3C);
    bus1[23] = 1'b1;
    #1;
    chk("R8 term clear", {24'd0, out1}, 32'h00);
    bus1[15:8] = 8'hFF;
    bus1[0] = 1'b0;
    #1;
    bus1[0] = 1'b1;
    #1;
    chk("R8 clear wins over clock edge", {24'd0, out1}, 32'h00);
    bus1[23] = 1'b0;
    #1;
    chk("R8 stays clear until next edge", {24'd0, out1}, 32'h00);
    bus1[0] = 1'b0;
    #1;
    bus1[0] = 1'b1;
    #1;
    chk("R8 capture after clear", {24'd0, out1}, 32'hFF);
    bus1[5] = 1'b0;
    #1;
    chk("R9 u1 outEn high", {31'd0, oe1}, 32'd1);
    bus1[5] = 1'b1;
    #1;
    chk("R9 u1 outEn low", {31'd0, oe1}, 32'd0);
    rstN = 1'b0;
    #1;
    chk("R6 async clear u1", {24'd0, out1}, 32'h00);
    finishRun();
  end
endmodule